// File: doc/BRIEF.md
# Flash-to-SRAM Image Preloader

After a start request, this block copies a raw colour image from a byte-wide nonvolatile memory into a 16-bit static RAM. The source image is a raster in which each pixel takes three consecutive bytes: red, then green, then blue. The memory has a single address and data path, so the block reads the three bytes one at a time. It drops the low bits of each channel, packs the result into one 5-6-5 word and writes that word to the SRAM. After each write the SRAM address advances by one.

The source memory is slow. Every read holds the address for a fixed wait window, and the data is taken at the end of that window. A second window of the same length follows every address increment. A start-up delay runs before the first read. The copy ends after a fixed pixel count, and then a sticky done flag rises. Three status digits, meant for a seven-segment display, show how far the sequence has come.

Top module: `img_preload`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the outputs are all zero: both addresses, the read strobe, the write strobe, done and the three status digits.
- R2: A one-cycle `start` pulse in the idle state begins a start-up delay. `flash_rd` first goes high exactly `BOOT_CYC` cycles after the clock edge that accepted `start`, with `flash_addr` at 0.
- R3: Each flash read keeps `flash_rd` high and `flash_addr` steady for exactly `WAIT_CYC` consecutive cycles. The byte on `flash_data` is captured in the last cycle of that window.
- R4: `flash_addr` changes only in the cycle after a read window ends, and each change is +1. A gap of `WAIT_CYC` cycles follows each increment. The bytes of one pixel come from three consecutive addresses, in the order red, green, blue.
- R5: The SRAM word is {red[7:3], green[7:2], blue[7:3]}. Red occupies bits 15:11, green bits 10:5 and blue bits 4:0.
- R6: Each pixel produces exactly one single-cycle `sram_we` pulse. The address on that pulse is the pixel index, counting from 0, and it increments after the write. Consecutive writes are `6*WAIT_CYC+1` cycles apart.
- R7: After `PIXEL_CNT` writes, `done` goes high in the next cycle and stays high. No further flash reads or SRAM writes occur, and `flash_addr` stays at `3*PIXEL_CNT`.
- R8: The status digits are 0 until their event occurs. Digit 0 becomes 1 when `start` is accepted. Digit 1 becomes 2 when the first flash read begins. Digit 2 becomes 3 when `done` rises.
- R9: A `start` pulse during the delay, during the copy or after completion has no effect: the write spacing, the write count and the final addresses are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the preload sequence (acted on in idle only) |
| flash_addr | output | FADDR_W (22) | Byte address to the nonvolatile memory |
| flash_rd | output | 1 | Read window active |
| flash_data | input | FDATA_W (8) | Byte returned by the nonvolatile memory |
| sram_addr | output | SADDR_W (18) | SRAM word address |
| sram_wdata | output | 16 | Packed 5-6-5 pixel word |
| sram_we | output | 1 | SRAM write strobe, one cycle per pixel |
| done | output | 1 | Copy complete (sticky) |
| stat_dig0 | output | 4 | Status digit: 1 once started |
| stat_dig1 | output | 4 | Status digit: 2 once copying |
| stat_dig2 | output | 4 | Status digit: 3 once finished |

## Verification
A wrong byte-select value or a timer that runs off by one soon shows up as a swapped or shifted channel in the written word, or as a write spacing other than `6*WAIT_CYC+1`. Either one is visible on the first or second pixel. A faulty address counter appears at the first write, as an SRAM address that does not equal the pixel index or as a flash address that is not three times the count of finished pixels. A broken terminal-count compare shows up within one pixel time after the last expected write, as a missing `done` or an extra strobe.

// File: rtl/img_preload_pkg.sv
package img_preload_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_BOOT = 3'd1,
        ST_RD   = 3'd2,
        ST_GAP  = 3'd3,
        ST_WR   = 3'd4,
        ST_DONE = 3'd5
    } pl_state_e;

    localparam int          NUM_DIGITS = 3;
    localparam int          DIGIT_W    = 4;
    localparam int          CHANNELS   = 3;

    // digit i shows code i+1 once its event has fired
    function automatic logic [DIGIT_W-1:0] digit_code(input int idx);
        return DIGIT_W'(idx + 1);
    endfunction

endpackage

// File: rtl/img_preload_timer.sv
module img_preload_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int            CW  = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || cnt_q == TOP) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = run && (cnt_q == TOP);

endmodule

// File: rtl/img_preload_pack.sv
module img_preload_pack #(
    parameter int IN_W  = 8,
    parameter int R_W   = 5,
    parameter int G_W   = 6,
    parameter int B_W   = 5,
    localparam int OUT_W = R_W + G_W + B_W
) (
    input  logic [IN_W-1:0]  red,
    input  logic [IN_W-1:0]  grn,
    input  logic [IN_W-1:0]  blu,
    output logic [OUT_W-1:0] word
);
    // keep the most significant bits of each channel, red on top
    assign word = {red[IN_W-1 -: R_W], grn[IN_W-1 -: G_W], blu[IN_W-1 -: B_W]};

endmodule

// File: rtl/img_preload_status.sv
module img_preload_status
    import img_preload_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_DIGITS-1:0]             ev,
    output logic [NUM_DIGITS-1:0][DIGIT_W-1:0] dig
);
    logic [NUM_DIGITS-1:0][DIGIT_W-1:0] dig_d, dig_q;

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
        always_comb begin
            dig_d[i] = dig_q[i];
            if (ev[i]) begin
                dig_d[i] = digit_code(i);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dig_q[i] <= '0;
            end else begin
                dig_q[i] <= dig_d[i];
            end
        end
    end

    assign dig = dig_q;

endmodule

// File: rtl/img_preload.sv
module img_preload
    import img_preload_pkg::*;
#(
    parameter int FADDR_W   = 22,
    parameter int FDATA_W   = 8,
    parameter int SADDR_W   = 18,
    parameter int RED_BITS  = 5,
    parameter int GRN_BITS  = 6,
    parameter int BLU_BITS  = 5,
    parameter int WAIT_CYC  = 100,
    parameter int BOOT_CYC  = 1000,
    parameter int PIXEL_CNT = 213200
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    output logic [FADDR_W-1:0]                   flash_addr,
    output logic                                 flash_rd,
    input  logic [FDATA_W-1:0]                   flash_data,
    output logic [SADDR_W-1:0]                   sram_addr,
    output logic [RED_BITS+GRN_BITS+BLU_BITS-1:0] sram_wdata,
    output logic                                 sram_we,
    output logic                                 done,
    output logic [3:0]                           stat_dig0,
    output logic [3:0]                           stat_dig1,
    output logic [3:0]                           stat_dig2
);
    localparam logic [SADDR_W-1:0] LAST_PIX = SADDR_W'(PIXEL_CNT - 1);
    localparam logic [1:0]         LAST_CH  = 2'(CHANNELS - 1);

    typedef struct packed {
        pl_state_e          st;
        logic [FADDR_W-1:0] faddr;
        logic [SADDR_W-1:0] saddr;
        logic [1:0]         ch;
        logic [FDATA_W-1:0] r;
        logic [FDATA_W-1:0] g;
        logic [FDATA_W-1:0] b;
    } pl_regs_t;

    pl_regs_t st_d, st_q;

    logic boot_run, boot_last;
    logic wait_run, wait_last;
    logic ev_arm, ev_copy, ev_done;
    logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digits;

    img_preload_timer #(.LIMIT(BOOT_CYC)) u_boot_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (boot_run),
        .last  (boot_last)
    );

    img_preload_timer #(.LIMIT(WAIT_CYC)) u_wait_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (wait_run),
        .last  (wait_last)
    );

    always_comb begin
        st_d     = st_q;
        boot_run = 1'b0;
        wait_run = 1'b0;
        ev_arm   = 1'b0;
        ev_copy  = 1'b0;
        ev_done  = 1'b0;
        case (st_q.st)
            ST_IDLE: begin
                if (start) begin
                    st_d.st = ST_BOOT;
                    ev_arm  = 1'b1;
                end
            end
            ST_BOOT: begin
                boot_run = 1'b1;
                if (boot_last) begin
                    st_d.st = ST_RD;
                    ev_copy = 1'b1;
                end
            end
            ST_RD: begin
                wait_run = 1'b1;
                if (wait_last) begin
                    case (st_q.ch)
                        2'd0:    st_d.r = flash_data;
                        2'd1:    st_d.g = flash_data;
                        default: st_d.b = flash_data;
                    endcase
                    st_d.faddr = st_q.faddr + 1'b1;
                    st_d.st    = ST_GAP;
                end
            end
            ST_GAP: begin
                wait_run = 1'b1;
                if (wait_last) begin
                    if (st_q.ch == LAST_CH) begin
                        st_d.ch = '0;
                        st_d.st = ST_WR;
                    end else begin
                        st_d.ch = st_q.ch + 1'b1;
                        st_d.st = ST_RD;
                    end
                end
            end
            ST_WR: begin
                st_d.saddr = st_q.saddr + 1'b1;
                if (st_q.saddr == LAST_PIX) begin
                    st_d.st = ST_DONE;
                    ev_done = 1'b1;
                end else begin
                    st_d.st = ST_RD;
                end
            end
            ST_DONE: begin
                st_d.st = ST_DONE;
            end
            default: begin
                st_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{st: ST_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    img_preload_pack #(
        .IN_W (FDATA_W),
        .R_W  (RED_BITS),
        .G_W  (GRN_BITS),
        .B_W  (BLU_BITS)
    ) u_pack (
        .red  (st_q.r),
        .grn  (st_q.g),
        .blu  (st_q.b),
        .word (sram_wdata)
    );

    img_preload_status u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    ({ev_done, ev_copy, ev_arm}),
        .dig   (digits)
    );

    assign flash_addr = st_q.faddr;
    assign flash_rd   = (st_q.st == ST_RD);
    assign sram_addr  = st_q.saddr;
    assign sram_we    = (st_q.st == ST_WR);
    assign done       = (st_q.st == ST_DONE);
    assign stat_dig0  = digits[0];
    assign stat_dig1  = digits[1];
    assign stat_dig2  = digits[2];

endmodule

// File: rtl/img_preload_chk.sv
module img_preload_chk #(
    parameter int FADDR_W = 22,
    parameter int SADDR_W = 18
) (
    input logic               clk,
    input logic               rst_n,
    input logic [FADDR_W-1:0] flash_addr,
    input logic               flash_rd,
    input logic [SADDR_W-1:0] sram_addr,
    input logic               sram_we,
    input logic               done,
    input logic [3:0]         stat_dig2
);
    // R3: the address holds while a read window is open
    p_addr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_rd && $past(flash_rd)) |-> $stable(flash_addr));

    // R4: the flash address moves only as a read window closes, by one
    p_faddr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flash_addr) |-> ($past(flash_rd) && !flash_rd &&
                                  flash_addr == $past(flash_addr) + 1'b1));

    // R6: each write is a single-cycle pulse, then the SRAM address steps
    p_we_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |=> !sram_we);

    p_saddr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sram_we) |-> sram_addr == $past(sram_addr) + 1'b1);

    // R6: no write while a read is in flight
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(flash_rd && sram_we));

    // R7: done is sticky and the block is quiet afterwards
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    p_quiet_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!flash_rd && !sram_we));

    // R8: finish digit accompanies done
    p_done_digit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> stat_dig2 == 4'd3);

endmodule

bind img_preload img_preload_chk #(
    .FADDR_W (FADDR_W),
    .SADDR_W (SADDR_W)
) chk_i (.*);

// File: tb/img_preload_tb_top.sv
`timescale 1ns/1ps
module img_preload_tb_top;

    localparam int WAIT = 4;
    localparam int BOOT = 10;
    localparam int PIX  = 6;
    localparam int GAP  = 6 * WAIT + 1;

    // {red, green, blue, expected 5-6-5 word}
    localparam logic [39:0] VEC [PIX] = '{
        {8'hFF, 8'hFF, 8'hFF, 16'hFFFF},
        {8'h00, 8'h00, 8'h00, 16'h0000},
        {8'hF8, 8'h00, 8'h00, 16'hF800},
        {8'h07, 8'hFC, 8'h07, 16'h07E0},
        {8'h00, 8'h03, 8'hF8, 16'h001F},
        {8'hA5, 8'h5A, 8'hC3, 16'hA2D8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [21:0] flash_addr;
    logic        flash_rd;
    logic [7:0]  flash_data;
    logic [17:0] sram_addr;
    logic [15:0] sram_wdata;
    logic        sram_we;
    logic        done;
    logic [3:0]  stat_dig0, stat_dig1, stat_dig2;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    img_preload #(
        .WAIT_CYC  (WAIT),
        .BOOT_CYC  (BOOT),
        .PIXEL_CNT (PIX)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .flash_addr (flash_addr),
        .flash_rd   (flash_rd),
        .flash_data (flash_data),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .sram_we    (sram_we),
        .done       (done),
        .stat_dig0  (stat_dig0),
        .stat_dig1  (stat_dig1),
        .stat_dig2  (stat_dig2)
    );

    // source memory: two-cycle read latency
    function automatic logic [7:0] rom(input logic [21:0] a);
        int idx;
        if (a >= 22'(3 * PIX)) return 8'hEE;
        idx = int'(a) / 3;
        case (int'(a) % 3)
            0:       return VEC[idx][39:32];
            1:       return VEC[idx][31:24];
            default: return VEC[idx][23:16];
        endcase
    endfunction

    logic [7:0] rom_p1;
    always_ff @(posedge clk) begin
        rom_p1     <= rom(flash_addr);
        flash_data <= rom_p1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // port monitor
    int          rd_run = 0;
    int          rd_rises = 0;
    int          writes = 0;
    logic        rd_prev = 1'b0;
    logic [21:0] fa_prev = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (flash_rd) begin
                rd_run++;
            end else if (rd_run != 0) begin
                chk(rd_run == WAIT, "R3 read window length", rd_run, WAIT);
                rd_run = 0;
            end
            if (flash_rd && !rd_prev) rd_rises++;
            if (sram_we) writes++;
            if (flash_addr != fa_prev)
                chk(flash_addr == fa_prev + 1'b1, "R4 flash address step",
                    32'(flash_addr), 32'(fa_prev + 1'b1));
            rd_prev = flash_rd;
            fa_prev = flash_addr;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int n;
        int gap;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(flash_addr == 0 && sram_addr == 0, "R1 addresses in reset",
            {flash_addr[15:0], sram_addr[15:0]}, 0);
        chk(!flash_rd && !sram_we && !done, "R1 strobes in reset",
            {flash_rd, sram_we, done}, 0);
        chk(stat_dig0 == 0 && stat_dig1 == 0 && stat_dig2 == 0, "R1 digits in reset",
            {stat_dig0, stat_dig1, stat_dig2}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!flash_rd && !sram_we && !done && stat_dig0 == 0, "R1 idle after reset",
            {flash_rd, sram_we, done, stat_dig0}, 0);

        // R2 start and boot delay
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(stat_dig0 == 4'd1 && stat_dig1 == 0, "R8 start digit",
            {stat_dig0, stat_dig1}, {4'd1, 4'd0});
        n = 0;
        while (!flash_rd) begin
            if (n == 3) start = 1'b1;   // R9 start during boot ignored
            if (n == 4) start = 1'b0;
            @(negedge clk);
            n++;
        end
        chk(n == BOOT, "R2 boot delay", n, BOOT);
        chk(flash_addr == 0, "R2 first flash address", 32'(flash_addr), 0);
        chk(stat_dig1 == 4'd2 && stat_dig2 == 0, "R8 copy digit",
            {stat_dig1, stat_dig2}, {4'd2, 4'd0});

        // table walk: one SRAM write per vector
        for (int p = 0; p < PIX; p++) begin
            if (p == 0) begin
                while (!sram_we) @(negedge clk);
            end else begin
                gap = 0;
                do begin
                    if (p == 2 && gap == 3) start = 1'b1;  // R9 start mid-copy
                    if (p == 2 && gap == 4) start = 1'b0;
                    @(negedge clk);
                    gap++;
                end while (!sram_we);
                chk(gap == GAP, "R6 write spacing", gap, GAP);
            end
            chk(sram_addr == 18'(p), "R6 write address", 32'(sram_addr), p);
            chk(sram_wdata == VEC[p][15:0], "R5 packed word", sram_wdata, VEC[p][15:0]);
            chk(flash_addr == 22'(3 * (p + 1)), "R4 bytes consumed", 32'(flash_addr),
                3 * (p + 1));
        end

        // R7 completion
        @(negedge clk);
        chk(done == 1'b1, "R7 done rises", done, 1);
        chk(stat_dig2 == 4'd3 && stat_dig0 == 4'd1 && stat_dig1 == 4'd2,
            "R8 finish digit", {stat_dig0, stat_dig1, stat_dig2}, 12'h123);

        // R9 start after done ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        chk(done == 1'b1, "R7 done sticky", done, 1);
        chk(writes == PIX, "R7 write count", writes, PIX);
        chk(rd_rises == 3 * PIX, "R9 read count", rd_rises, 3 * PIX);
        chk(flash_addr == 22'(3 * PIX), "R9 final flash address", 32'(flash_addr),
            3 * PIX);
        chk(sram_addr == 18'(PIX), "R9 final SRAM address", 32'(sram_addr), PIX);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule